// File: doc/BRIEF.md
# Gated-Window Oscillator Ratio Counter

This block measures how many times faster one oscillator runs than another and presents the result as a three-digit decimal number. A measured oscillator, whose period depends on an unknown capacitor, is halved in rate to form a measurement window that stays high for exactly one of its periods and low for the next. While the window is high, rising edges of a reference oscillator advance a chain of decimal counters. Both oscillators share the same resistor and inverter type, so the count equals the ratio of the capacitances with no calibration constant.

All logic runs on one fast system clock. The measured oscillator, the reference oscillator and a slow display-update request are asynchronous inputs. Each is synchronized and edge-detected inside the block. A falling edge on the update request arms a pending flag. The next end of a window then copies the finished count into holding registers, which drive a display. A display driven this way changes at the request rate, not at the much faster window rate. The window level is also brought out so that range-selection logic elsewhere can sample over/underflow at the same boundary.

Top module: `gated_ratio_counter`

## Requirements
- R1: The window output is low after reset. It toggles on every synchronized rising edge of the measured oscillator, so it is high for one full measured period and low for the next.
- R2: A synchronized rising edge of the reference oscillator advances the count only while the window is high. A high window therefore counts the reference-to-measured frequency ratio, within one edge.
- R3: The count and the held value are three BCD digits, each 0 to 9. Digit i sits at bits 4i+3:4i, with digit 0 holding the units. A digit that wraps from 9 to 0 carries one into the next digit.
- R4: A count of 999 followed by one more counted edge becomes 000, so the held result is the ratio modulo 1000.
- R5: A synchronized falling edge of the update request sets a pending flag. If that edge coincides with a latch, the flag remains set for the next window.
- R6: A window end is a measured rising edge while the window is high. At a window end with the flag set, the holding registers take the count reached in that window, and the flag clears.
- R7: The holding registers change at no other time. Without a fresh update-request falling edge, further windows leave the output unchanged.
- R8: Every window end clears the count after the copy is taken. A reference edge in that same cycle is not counted, and the count stays zero while the window is low. A stopped reference therefore produces a held value of 0.
- R9: An input level that is stable before clock edge k takes effect on the outputs just after edge k+2. This is two synchronizer stages plus the edge register.
- R10: An active-low rst_n clears the window, the count, the flag and the holding registers asynchronously. Its release is synchronized, and normal operation starts on the third clock edge after release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| meas_osc_i | input | 1 | Measured (unknown capacitor) oscillator, asynchronous |
| ref_osc_i | input | 1 | Reference oscillator, asynchronous |
| upd_req_i | input | 1 | Slow display-update request, acts on its falling edge |
| held_bcd_o | output | 12 | Held three-digit BCD result, digit 0 in bits 3:0 |
| window_o | output | 1 | Measurement window phase |

## Verification
Every input edge reaches the outputs just after the third rising clock edge that follows it. The window toggles then, a counted reference edge advances the internal count then, and a latch lands on the held output in that same cycle. The bench drives inputs on falling clock edges and advances a behavioural reference model on rising edges using a three-deep history of sampled inputs. It compares window and held value at the next falling edge, so every expected value sits in the exact cycle in which the design produces it. A directed check counts clock edges from one measured-input step to the window change to confirm the latency of three edges.

// File: rtl/gratio_pkg.sv
package gratio_pkg;

  localparam int unsigned DIGIT_W = 4;

  typedef logic [DIGIT_W-1:0] bcd_t;

  localparam bcd_t BCD_TOP  = 4'd9;
  localparam bcd_t BCD_ZERO = 4'd0;

  localparam int unsigned NUM_CH = 3;

  typedef enum int unsigned {
    CH_MEAS = 0,
    CH_REF  = 1,
    CH_UPD  = 2
  } chan_e;

  function automatic bcd_t bcd_step(input bcd_t d);
    return (d == BCD_TOP) ? BCD_ZERO : bcd_t'(d + 4'd1);
  endfunction

endpackage

// File: rtl/edge_sync.sv
module edge_sync #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic level_o,
  output logic rise_o,
  output logic fall_o
);

  localparam int unsigned TOP = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] chain_q;
  logic [SYNC_STAGES-1:0] chain_d;
  logic                   prev_q;
  logic                   prev_d;

  generate
    if (SYNC_STAGES == 1) begin : g_one
      always_comb chain_d = async_i;
    end else begin : g_many
      always_comb chain_d = {chain_q[SYNC_STAGES-2:0], async_i};
    end
  endgenerate

  always_comb begin
    prev_d  = chain_q[TOP];
    level_o = chain_q[TOP];
    rise_o  = chain_q[TOP] & ~prev_q;
    fall_o  = ~chain_q[TOP] & prev_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
      prev_q  <= 1'b0;
    end else begin
      chain_q <= chain_d;
      prev_q  <= prev_d;
    end
  end

endmodule

// File: rtl/window_div.sv
module window_div (
  input  logic clk,
  input  logic rst_n,
  input  logic meas_rise_i,
  output logic window_o,
  output logic win_end_o
);

  logic win_q;
  logic win_d;
  logic win_en;

  always_comb begin
    win_en    = meas_rise_i;
    win_d     = ~win_q;
    win_end_o = meas_rise_i & win_q;
    window_o  = win_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_q <= 1'b0;
    end else if (win_en) begin
      win_q <= win_d;
    end
  end

endmodule

// File: rtl/bcd_chain.sv
module bcd_chain
  import gratio_pkg::*;
#(
  parameter int unsigned DIGITS = 3
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        inc_i,
  input  logic                        clr_i,
  output logic [DIGITS*DIGIT_W-1:0]   count_o
);

  logic [DIGITS:0] carry;

  always_comb carry[0] = inc_i;

  generate
    for (genvar i = 0; i < DIGITS; i++) begin : g_digit
      bcd_t dig_q;
      bcd_t dig_d;
      logic dig_en;

      always_comb begin
        carry[i+1] = carry[i] & (dig_q == BCD_TOP);
        dig_en     = clr_i | carry[i];
        dig_d      = clr_i ? BCD_ZERO : bcd_step(dig_q);
        count_o[i*DIGIT_W +: DIGIT_W] = dig_q;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          dig_q <= BCD_ZERO;
        end else if (dig_en) begin
          dig_q <= dig_d;
        end
      end
    end
  endgenerate

endmodule

// File: rtl/update_latch.sv
module update_latch #(
  parameter int unsigned WIDTH = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             upd_fall_i,
  input  logic             win_end_i,
  input  logic [WIDTH-1:0] count_i,
  output logic [WIDTH-1:0] held_o,
  output logic             pend_o
);

  logic             pend_q;
  logic             pend_d;
  logic             take;
  logic [WIDTH-1:0] held_q;

  always_comb begin
    take = win_end_i & pend_q;
    if (upd_fall_i) begin
      pend_d = 1'b1;
    end else if (take) begin
      pend_d = 1'b0;
    end else begin
      pend_d = pend_q;
    end
    held_o = held_q;
    pend_o = pend_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
    end else begin
      pend_q <= pend_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held_q <= '0;
    end else if (take) begin
      held_q <= count_i;
    end
  end

endmodule

// File: rtl/gated_ratio_counter.sv
module gated_ratio_counter
  import gratio_pkg::*;
#(
  parameter int unsigned DIGITS      = 3,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      meas_osc_i,
  input  logic                      ref_osc_i,
  input  logic                      upd_req_i,
  output logic [DIGITS*DIGIT_W-1:0] held_bcd_o,
  output logic                      window_o
);

  localparam int unsigned CW = DIGITS * DIGIT_W;

  logic [1:0] rst_pipe_q;
  logic       rst_i_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe_q <= 2'b00;
    end else begin
      rst_pipe_q <= {rst_pipe_q[0], 1'b1};
    end
  end

  always_comb rst_i_n = rst_pipe_q[1];

  logic [NUM_CH-1:0] async_vec;
  logic [NUM_CH-1:0] lvl_vec;
  logic [NUM_CH-1:0] rise_vec;
  logic [NUM_CH-1:0] fall_vec;

  always_comb begin
    async_vec[CH_MEAS] = meas_osc_i;
    async_vec[CH_REF]  = ref_osc_i;
    async_vec[CH_UPD]  = upd_req_i;
  end

  generate
    for (genvar c = 0; c < NUM_CH; c++) begin : g_sync
      edge_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_i_n),
        .async_i (async_vec[c]),
        .level_o (lvl_vec[c]),
        .rise_o  (rise_vec[c]),
        .fall_o  (fall_vec[c])
      );
    end
  endgenerate

  logic meas_rise;
  logic ref_rise;
  logic upd_fall;
  logic win;
  logic win_end;
  logic cnt_inc;
  logic pend;
  logic [CW-1:0] cnt_flat;

  always_comb begin
    meas_rise = rise_vec[CH_MEAS];
    ref_rise  = rise_vec[CH_REF];
    upd_fall  = fall_vec[CH_UPD];
  end

  window_div u_win (
    .clk         (clk),
    .rst_n       (rst_i_n),
    .meas_rise_i (meas_rise),
    .window_o    (win),
    .win_end_o   (win_end)
  );

  always_comb cnt_inc = ref_rise & win & ~win_end;

  bcd_chain #(.DIGITS(DIGITS)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_i_n),
    .inc_i   (cnt_inc),
    .clr_i   (win_end),
    .count_o (cnt_flat)
  );

  update_latch #(.WIDTH(CW)) u_hold (
    .clk        (clk),
    .rst_n      (rst_i_n),
    .upd_fall_i (upd_fall),
    .win_end_i  (win_end),
    .count_i    (cnt_flat),
    .held_o     (held_bcd_o),
    .pend_o     (pend)
  );

  always_comb window_o = win;

endmodule

// File: rtl/gated_ratio_counter_chk.sv
module gated_ratio_counter_chk #(
  parameter int unsigned CW = 12
) (
  input logic          clk,
  input logic          rst_i_n,
  input logic          meas_rise,
  input logic          upd_fall,
  input logic          win_end,
  input logic          pend,
  input logic          win,
  input logic [CW-1:0] cnt_flat,
  input logic [CW-1:0] held_bcd_o
);

  function automatic logic all_bcd(input logic [CW-1:0] v);
    logic ok;
    ok = 1'b1;
    for (int i = 0; i < CW / 4; i++) begin
      if (v[i*4 +: 4] > 4'd9) ok = 1'b0;
    end
    return ok;
  endfunction

  assert_win_toggle_R1: assert property (@(posedge clk) disable iff (!rst_i_n)
    meas_rise |=> (win != $past(win)));

  assert_win_hold_R1: assert property (@(posedge clk) disable iff (!rst_i_n)
    !meas_rise |=> $stable(win));

  assert_digits_valid_R3: assert property (@(posedge clk) disable iff (!rst_i_n)
    all_bcd(cnt_flat) && all_bcd(held_bcd_o));

  assert_pend_set_R5: assert property (@(posedge clk) disable iff (!rst_i_n)
    upd_fall |=> pend);

  assert_pend_clear_R6: assert property (@(posedge clk) disable iff (!rst_i_n)
    (win_end && pend && !upd_fall) |=> !pend);

  assert_latch_value_R6: assert property (@(posedge clk) disable iff (!rst_i_n)
    (win_end && pend) |=> (held_bcd_o == $past(cnt_flat)));

  assert_held_stable_R7: assert property (@(posedge clk) disable iff (!rst_i_n)
    !(win_end && pend) |=> $stable(held_bcd_o));

  assert_idle_zero_R8: assert property (@(posedge clk) disable iff (!rst_i_n)
    !win |-> (cnt_flat == '0));

  assert_end_clear_R8: assert property (@(posedge clk) disable iff (!rst_i_n)
    win_end |=> (cnt_flat == '0));

endmodule

bind gated_ratio_counter gated_ratio_counter_chk #(.CW(CW)) u_chk (
  .clk        (clk),
  .rst_i_n    (rst_i_n),
  .meas_rise  (meas_rise),
  .upd_fall   (upd_fall),
  .win_end    (win_end),
  .pend       (pend),
  .win        (win),
  .cnt_flat   (cnt_flat),
  .held_bcd_o (held_bcd_o)
);

// File: tb/gated_ratio_counter_bench.sv
`timescale 1ns/1ps
module gated_ratio_counter_bench;

  logic        clk;
  logic        rst_n;
  logic        meas_osc;
  logic        ref_osc;
  logic        upd_req;
  logic [11:0] held_bcd;
  logic        window;

  gated_ratio_counter u_gated_ratio_counter (
    .clk        (clk),
    .rst_n      (rst_n),
    .meas_osc_i (meas_osc),
    .ref_osc_i  (ref_osc),
    .upd_req_i  (upd_req),
    .held_bcd_o (held_bcd),
    .window_o   (window)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  int n_cmp = 0;
  int n_bad = 0;
  int cyc   = 0;
  bit done  = 0;

  task automatic check(input int act, input int exp, input string tag);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  task automatic check_rng(input int act, input int lo, input int hi, input string tag);
    n_cmp++;
    if (act < lo || act > hi) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d..%0d", tag, act, lo, hi);
    end
  endtask

  function automatic int dec_val(input logic [11:0] v);
    return int'(v[11:8]) * 100 + int'(v[7:4]) * 10 + int'(v[3:0]);
  endfunction

  // oscillator generators
  bit osc_en = 0;
  bit ref_en = 1;
  int hm = 50;
  int hr = 5;
  int mc = 0;
  int rc = 0;

  always @(negedge clk) begin
    if (osc_en) begin
      if (mc >= hm - 1) begin mc = 0; meas_osc <= ~meas_osc; end else mc++;
      if (ref_en) begin
        if (rc >= hr - 1) begin rc = 0; ref_osc <= ~ref_osc; end else rc++;
      end
    end
  end

  // behavioural reference model
  bit [2:0] hist[$];
  int  m_rcnt = 0;
  bit  m_win = 0;
  bit  m_pend = 0;
  int  m_cnt = 0;
  int  m_held = 0;
  int  m_ends = 0;
  bit  m_live = 0;

  always @(posedge clk) begin
    cyc++;
    if (!rst_n || m_rcnt < 2) begin
      if (!rst_n) m_rcnt = 0; else m_rcnt++;
      hist = '{3'b000, 3'b000, 3'b000};
      m_win = 0; m_pend = 0; m_cnt = 0; m_held = 0;
      m_live = (m_rcnt >= 2);
    end else begin
      bit mr, rr, uf, e;
      mr = hist[1][0] & ~hist[2][0];
      rr = hist[1][1] & ~hist[2][1];
      uf = ~hist[1][2] & hist[2][2];
      e  = mr & m_win;
      if (e && m_pend) m_held = m_cnt;
      if (e) begin m_cnt = 0; m_ends++; end
      else if (m_win && rr) m_cnt = (m_cnt + 1) % 1000;
      if (uf) m_pend = 1; else if (e) m_pend = 0;
      if (mr) m_win = ~m_win;
      hist.push_front({upd_req, ref_osc, meas_osc});
      void'(hist.pop_back());
    end
  end

  always @(negedge clk) begin
    if (rst_n && m_live && !done) begin
      check(int'(window), int'(m_win), "R1 window phase");
      check(dec_val(held_bcd), m_held, "R6 held value");
    end
  end

  task automatic wait_windows(input int n);
    int start;
    start = m_ends;
    while (m_ends < start + n) @(negedge clk);
  endtask

  task automatic pulse_update();
    upd_req <= 1'b1;
    repeat (8) @(negedge clk);
    upd_req <= 1'b0;
    repeat (8) @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0; meas_osc = 1'b0; ref_osc = 1'b0; upd_req = 1'b0;
    repeat (5) @(negedge clk);
    check(dec_val(held_bcd), 0, "R10 held in reset");
    check(int'(window), 0, "R10 window in reset");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(dec_val(held_bcd), 0, "R10 held after release");

    // ratio 10 without a request: output must not move
    hm = 50; hr = 5; osc_en = 1;
    wait_windows(4);
    check(dec_val(held_bcd), 0, "R7 no request keeps held");

    pulse_update();
    wait_windows(2);
    check_rng(dec_val(held_bcd), 9, 11, "R2 ratio ten");

    // frequency change with no further request
    hm = 600; hr = 1;
    wait_windows(3);
    check_rng(dec_val(held_bcd), 9, 11, "R7 R5 single latch per request");

    pulse_update();
    wait_windows(2);
    check_rng(dec_val(held_bcd), 599, 601, "R3 three-digit carry");
    check_rng(int'(held_bcd[11:8]), 5, 6, "R3 hundreds digit field");

    // overflow wraps modulo 1000
    hm = 1100; hr = 1;
    wait_windows(2);
    pulse_update();
    wait_windows(2);
    check_rng(dec_val(held_bcd), 99, 101, "R4 wrap past 999");

    // stopped reference: cleared count gives zero
    ref_en = 0;
    wait_windows(2);
    pulse_update();
    wait_windows(2);
    check(dec_val(held_bcd), 0, "R8 cleared each window");

    // latency of one measured edge
    osc_en = 0;
    meas_osc <= 1'b0;
    repeat (10) @(negedge clk);
    begin
      bit w0;
      int n;
      w0 = window;
      n = 0;
      meas_osc <= 1'b1;
      for (int k = 1; k <= 6; k++) begin
        @(negedge clk);
        if (window != w0 && n == 0) n = k;
      end
      check(n, 3, "R9 edges to window change");
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule